// File: doc/BRIEF.md
# Serial Configuration Chain Shift Engine

This block lets a host program long serial configuration chains, one chain per lane group, through two memory-mapped registers. A control register sets the serial clock rate, which group's return data is observed, and a route mask saying which groups may be clocked at all. A data register carries a 32-bit shift window, a bit count, a one-hot group select and three command bits: shift, update and capture. Writing one command bit starts an operation. The engine generates a slow serial clock, moves bits through the selected chain, or pulses the update or capture strobe. It then clears the command bit so the host can poll for completion.

A shift runs 1 to 32 bits. The window sends its LSB first and takes the returning chain bits in at its MSB. After N bits, the host finds the N returned bits in the upper N positions of the window. Chains longer than 32 bits are covered by repeated shifts. Update copies the chain contents into the lane group's live state, and capture reloads the chain from that state.

Top module: `chain_shift_ctrl`

## Requirements
- R1: Register access uses `csr_addr_i` = 0 for control and 1 for data. Control fields: divide exponent at bits [3:0], observed group at [9:8], route mask at [19:16]. Data fields: window at [31:0], count at [36:32], shift command at bit 40, update at 41, capture at 42, one-hot group select at [51:48].
- R2: While an operation runs, `ser_clk_o` has a period of 2^(exponent+2) system clock cycles. The serial clock is low when the engine is idle.
- R3: A count field of n-1 makes a shift produce exactly n rising serial clock edges, for n from 1 to 32.
- R4: Window bit 0 goes onto `ser_dat_o` first, then bit 1, and so on. The bit returning from the chain on each rising edge enters the window MSB while the window moves toward its LSB.
- R5: After an n-bit shift, the window reads (V >> n) | (R << (32-n)). Here V is the written value and R holds the returned bits, with the first returned bit in R bit 0.
- R6: A command bit reads 1 from the write until its operation ends, and reads 0 afterwards.
- R7: Update and capture each produce one rising serial clock edge with `ser_upd_o` or `ser_cap_o` high. The chain model uses that edge to copy chain to lanes (update) or lanes to chain (capture).
- R8: `grp_en_o[g]` is high during an operation only if select bit g and route bit g are both set. The return bit is taken from `ser_ret_i` at the observed group index.
- R9: `ser_dat_o`, `ser_upd_o` and `ser_cap_o` change only while `ser_clk_o` is low. The chain samples them on the rising edge.
- R10: A write to either register while a command bit is 1 is ignored.
- R11: A data write with more than one command bit set stores the window, count and select fields. It starts nothing and leaves all command bits at 0.
- R12: After reset both registers read 0, the serial clock is low and all group enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_i | input | 1 | 0 selects control, 1 selects data |
| csr_wdata_i | input | 64 | Write data |
| csr_rdata_o | output | 64 | Read data for the addressed register |
| ser_clk_o | output | 1 | Divided serial clock |
| ser_dat_o | output | 1 | Serial data into the chain |
| ser_upd_o | output | 1 | Update strobe |
| ser_cap_o | output | 1 | Capture strobe |
| grp_en_o | output | NUM_GRP | Per-group chain enable |
| ser_ret_i | input | NUM_GRP | Per-group chain return bit |

## Verification
Shifts of 1, 7 and 32 bits with different window values separate off-by-one count handling from the window's bit ordering and from the (V >> n) return placement. A capture followed by shifting a full four-segment chain out of one group checks capture against the lane state. Shifting a known pattern into another group and then updating it checks update, while the untouched groups show that the shared serial lines do not disturb them. A shift into a group whose route bit is cleared returns a constant bit, which separates enable gating from return muxing. A long shift with control and data writes in flight, and a write with two command bits set, show that those writes change neither the result nor the serial activity.

// File: rtl/chain_shift_pkg.sv
package chain_shift_pkg;
  localparam int EXP_LSB   = 0;
  localparam int MUX_LSB   = 8;
  localparam int ROUTE_LSB = 16;
  localparam int CNT_LSB   = 32;
  localparam int CMD_LSB   = 40;  // shift, update, capture
  localparam int SEL_LSB   = 48;

  typedef enum logic [1:0] {
    OP_SHIFT   = 2'd0,
    OP_UPDATE  = 2'd1,
    OP_CAPTURE = 2'd2
  } op_e;
endpackage

// File: rtl/chain_clk_div.sv
module chain_clk_div #(
  parameter int EXP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << EXP_W) + 1;

  logic [CNT_W-1:0] cnt_q, lim;

  // half serial period = 2^(exp+1) cycles
  assign lim    = (CNT_W'(1) << ({1'b0, exp_i} + 1'b1)) - CNT_W'(1);
  assign tick_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  AST_DIV_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q <= lim); // R2
endmodule

// File: rtl/chain_seq.sv
module chain_seq
  import chain_shift_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic          start_i,
  input  op_e           op_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [DW-1:0] val_i,
  input  logic          tdo_i,
  output logic          active_o,
  output logic          done_o,
  output logic          tck_o,
  output logic          tdi_o,
  output logic          upd_o,
  output logic          cap_o,
  output logic [DW-1:0] shreg_o
);
  logic          active_q, tck_q, tdi_q, upd_q, cap_q;
  logic [CW-1:0] left_q;
  logic [DW-1:0] shreg_q;
  op_e           op_q;
  logic          more;

  assign more   = (op_q == OP_SHIFT) && (left_q != '0);
  assign done_o = active_q && tick_i && tck_q && !more;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      tck_q    <= 1'b0;
      tdi_q    <= 1'b0;
      upd_q    <= 1'b0;
      cap_q    <= 1'b0;
      left_q   <= '0;
      shreg_q  <= '0;
      op_q     <= OP_SHIFT;
    end else if (load_i) begin
      shreg_q <= val_i;
      if (start_i) begin
        active_q <= 1'b1;
        op_q     <= op_i;
        left_q   <= cnt_i;
        tck_q    <= 1'b0;
        tdi_q    <= val_i[0];
        upd_q    <= (op_i == OP_UPDATE);
        cap_q    <= (op_i == OP_CAPTURE);
      end
    end else if (active_q && tick_i) begin
      if (!tck_q) begin
        tck_q <= 1'b1;
        if (op_q == OP_SHIFT) shreg_q <= {tdo_i, shreg_q[DW-1:1]};
      end else begin
        tck_q <= 1'b0;
        if (more) begin
          left_q <= left_q - 1'b1;
          tdi_q  <= shreg_q[0];
        end else begin
          active_q <= 1'b0;
          upd_q    <= 1'b0;
          cap_q    <= 1'b0;
        end
      end
    end
  end

  assign active_o = active_q;
  assign tck_o    = tck_q;
  assign tdi_o    = tdi_q;
  assign upd_o    = upd_q;
  assign cap_o    = cap_q;
  assign shreg_o  = shreg_q;

  AST_DRIVE_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_q |-> $stable(tdi_q) && $stable(upd_q) && $stable(cap_q)); // R9
  AST_END_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !tck_q && !active_q); // R6
endmodule

// File: rtl/chain_shift_ctrl.sv
module chain_shift_ctrl
  import chain_shift_pkg::*;
#(
  parameter int NUM_GRP = 4,
  parameter int EXP_W   = 4,
  parameter int DW      = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csr_we_i,
  input  logic               csr_addr_i,
  input  logic [63:0]        csr_wdata_i,
  output logic [63:0]        csr_rdata_o,
  output logic               ser_clk_o,
  output logic               ser_dat_o,
  output logic               ser_upd_o,
  output logic               ser_cap_o,
  output logic [NUM_GRP-1:0] grp_en_o,
  input  logic [NUM_GRP-1:0] ser_ret_i
);
  localparam int GW = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam int CW = $clog2(DW);

  logic [EXP_W-1:0]   exp_q;
  logic [GW-1:0]      mux_q;
  logic [NUM_GRP-1:0] route_q, sel_q;
  logic [CW-1:0]      cnt_q;
  logic [2:0]         cmd_q, wr_cmd;
  logic               busy, wr_ok, cmd_one, load, start, tick, active, done, tdo;
  logic [DW-1:0]      shreg;
  op_e                op;

  assign busy    = |cmd_q;
  assign wr_ok   = csr_we_i && !busy;
  assign wr_cmd  = csr_wdata_i[CMD_LSB +: 3];
  assign cmd_one = $onehot(wr_cmd);
  assign load    = wr_ok && csr_addr_i;
  assign start   = load && cmd_one;
  assign tdo     = ser_ret_i[mux_q];

  always_comb begin
    unique case (1'b1)
      wr_cmd[1]: op = OP_UPDATE;
      wr_cmd[2]: op = OP_CAPTURE;
      default:   op = OP_SHIFT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q   <= '0;
      mux_q   <= '0;
      route_q <= '0;
    end else if (wr_ok && !csr_addr_i) begin
      exp_q   <= csr_wdata_i[EXP_LSB +: EXP_W];
      mux_q   <= csr_wdata_i[MUX_LSB +: GW];
      route_q <= csr_wdata_i[ROUTE_LSB +: NUM_GRP];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= '0;
      cmd_q <= '0;
    end else if (load) begin
      cnt_q <= csr_wdata_i[CNT_LSB +: CW];
      sel_q <= csr_wdata_i[SEL_LSB +: NUM_GRP];
      cmd_q <= cmd_one ? wr_cmd : 3'b000;
    end else if (done) begin
      cmd_q <= '0;
    end
  end

  chain_clk_div #(.EXP_W(EXP_W)) u_div (
    .clk_i, .rst_ni, .en_i(active), .exp_i(exp_q), .tick_o(tick)
  );

  chain_seq #(.DW(DW), .CW(CW)) u_seq (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(load), .start_i(start),
    .op_i(op), .cnt_i(csr_wdata_i[CNT_LSB +: CW]), .val_i(csr_wdata_i[DW-1:0]),
    .tdo_i(tdo), .active_o(active), .done_o(done), .tck_o(ser_clk_o),
    .tdi_o(ser_dat_o), .upd_o(ser_upd_o), .cap_o(ser_cap_o), .shreg_o(shreg)
  );

  assign grp_en_o = active ? (sel_q & route_q) : '0;

  always_comb begin
    csr_rdata_o = '0;
    if (!csr_addr_i) begin
      csr_rdata_o[EXP_LSB +: EXP_W]     = exp_q;
      csr_rdata_o[MUX_LSB +: GW]        = mux_q;
      csr_rdata_o[ROUTE_LSB +: NUM_GRP] = route_q;
    end else begin
      csr_rdata_o[DW-1:0]             = shreg;
      csr_rdata_o[CNT_LSB +: CW]      = cnt_q;
      csr_rdata_o[CMD_LSB +: 3]       = cmd_q;
      csr_rdata_o[SEL_LSB +: NUM_GRP] = sel_q;
    end
  end

  AST_CMD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_q)); // R11
  AST_CTRL_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_i && busy |=> $stable(exp_q) && $stable(mux_q) && $stable(route_q)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !ser_clk_o && grp_en_o == '0); // R12
  AST_CMD_TRACKS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> busy); // R6
endmodule

// File: tb/chain_shift_ctrl_bench.sv
`timescale 1ns/1ps
module chain_shift_ctrl_bench;
  localparam int NG  = 4;
  localparam int SEG = 268;
  localparam int LEN = 4 * SEG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          we = 1'b0, addr = 1'b0;
  logic [63:0]   wdata = '0, rdata;
  logic          tck, tdi, upd, cap;
  logic [NG-1:0] gen, tdo;

  chain_shift_ctrl u_chain_shift_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .ser_clk_o(tck), .ser_dat_o(tdi),
    .ser_upd_o(upd), .ser_cap_o(cap), .grp_en_o(gen), .ser_ret_i(tdo)
  );

  // behavioural chains and lane state
  logic [LEN-1:0] chain_m [NG];
  logic [LEN-1:0] lanes_m [NG];
  logic [LEN-1:0] ref_chain [NG];
  logic [LEN-1:0] ref_lanes [NG];

  always @(posedge tck) begin
    for (int g = 0; g < NG; g++) begin
      if (gen[g]) begin
        if (upd)      lanes_m[g] <= chain_m[g];
        else if (cap) chain_m[g] <= lanes_m[g];
        else          chain_m[g] <= {tdi, chain_m[g][LEN-1:1]};
      end
    end
  end

  always_comb for (int g = 0; g < NG; g++) tdo[g] = chain_m[g][0];

  int  rises = 0;
  time last_rise = 0, period = 0;
  always @(posedge tck) begin
    period    = $time - last_rise;
    last_rise = $time;
    rises++;
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [31:0] exp_q [$];
  logic [31:0] act_q [$];
  string       tag_q [$];

  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [31:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {32'b0, a}, {32'b0, e});
    end
  end

  task automatic csr_wr(logic a, logic [63:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic csr_rd(logic a, output logic [63:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_idle(output logic [63:0] d);
    do csr_rd(1'b1, d); while (d[42:40] != 3'b000);
  endtask

  function automatic logic [63:0] ctrl_word(int e, int m, logic [3:0] route);
    return 64'(e) | (64'(m) << 8) | (64'(route) << 16);
  endfunction

  function automatic logic [63:0] data_word(int g, int n, logic [2:0] cmd, logic [31:0] v);
    return 64'(v) | (64'(n - 1) << 32) | (64'(cmd) << 40) | (64'(1 << g) << 48);
  endfunction

  // reference shift; returns expected window
  function automatic logic [31:0] ref_shift(int g, int n, logic [31:0] v, bit en);
    logic [31:0] outb = '0;
    logic [63:0] w;
    for (int i = 0; i < n; i++) begin
      outb[i] = ref_chain[g][0];
      if (en) ref_chain[g] = {v[i], ref_chain[g][LEN-1:1]};
    end
    w = ({32'b0, v} >> n) | ({32'b0, outb} << (32 - n));
    return w[31:0];
  endfunction

  task automatic do_shift(int g, int n, logic [31:0] v, string tag, bit en = 1);
    logic [63:0] d;
    int r0;
    exp_q.push_back(ref_shift(g, n, v, en));
    tag_q.push_back(tag);
    r0 = rises;
    csr_wr(1'b1, data_word(g, n, 3'b001, v));
    csr_rd(1'b1, d);
    check("R6 shift command held while running", {63'b0, d[40]}, 64'd1);
    wait_idle(d);
    act_q.push_back(d[31:0]);
    check("R3 serial edges per shift", 64'(rises - r0), 64'(n));
  endtask

  task automatic do_strobe(int g, bit is_upd);
    logic [63:0] d;
    int r0;
    r0 = rises;
    csr_wr(1'b1, data_word(g, 1, is_upd ? 3'b010 : 3'b100, 32'h0));
    wait_idle(d);
    check("R7 one serial edge per strobe op", 64'(rises - r0), 64'd1);
    if (is_upd) ref_lanes[g] = ref_chain[g];
    else        ref_chain[g] = ref_lanes[g];
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    int r0;
    for (int g = 0; g < NG; g++) begin
      chain_m[g] = '0;
      for (int i = 0; i < LEN; i++) lanes_m[g][i] = ((i * 7 + g * 3) % 5) == 0;
      ref_chain[g] = chain_m[g];
      ref_lanes[g] = lanes_m[g];
    end
    #12 rst_n = 1'b1;

    // R12 reset state
    csr_rd(1'b0, d); check("R12 control after reset", d, 64'h0);
    csr_rd(1'b1, d); check("R12 data after reset", d, 64'h0);
    check("R12 serial clock low", {63'b0, tck}, 64'd0);
    check("R12 enables low", 64'(gen), 64'd0);

    // R1 layout readback
    csr_wr(1'b0, ctrl_word(0, 0, 4'hF));
    csr_rd(1'b0, d); check("R1 control readback", d, 64'h0000_0000_000F_0000);

    // R4 R5 shifts in group 0
    do_shift(0, 1, 32'h0000_0001, "R4 one-bit shift");
    do_shift(0, 7, 32'h0000_005A, "R5 seven-bit shift");
    do_shift(0, 32, 32'hDEAD_BEEF, "R5 full-window shift");
    check("R2 period at exponent 0", 64'(period), 64'd20);
    do_shift(0, 32, 32'h1234_5678, "R4 returns previous window");

    csr_wr(1'b0, ctrl_word(2, 0, 4'hF));
    do_shift(0, 5, 32'h0000_0013, "R5 shift at exponent 2");
    check("R2 period at exponent 2", 64'(period), 64'd80);

    // R7 capture in group 1, read whole chain out
    csr_wr(1'b0, ctrl_word(0, 1, 4'hF));
    do_strobe(1, 1'b0);
    for (int k = 0; k < LEN; k += 32)
      do_shift(1, (LEN - k) >= 32 ? 32 : LEN - k, 32'h0, "R7 captured lanes shifted out");

    // R7 update in group 2
    csr_wr(1'b0, ctrl_word(0, 2, 4'hF));
    for (int k = 0; k < LEN; k += 32)
      do_shift(2, (LEN - k) >= 32 ? 32 : LEN - k, 32'h9E37_79B9 ^ 32'(k), "R4 pattern into group 2");
    do_strobe(2, 1'b1);
    check("R7 update copies chain to lanes", {63'b0, lanes_m[2] === ref_lanes[2]}, 64'd1);
    check("R8 group 0 untouched", {63'b0, chain_m[0] === ref_chain[0]}, 64'd1);
    check("R8 group 1 untouched", {63'b0, chain_m[1] === ref_chain[1]}, 64'd1);

    // R8 route mask blocks group 3
    csr_wr(1'b0, ctrl_word(0, 3, 4'b0111));
    do_shift(3, 8, 32'h0000_00FF, "R8 unrouted group returns constant", 0);
    check("R8 unrouted chain unchanged", {63'b0, chain_m[3] === ref_chain[3]}, 64'd1);

    // R10 writes while busy
    csr_wr(1'b0, ctrl_word(2, 0, 4'hF));
    exp_q.push_back(ref_shift(0, 32, 32'hA5A5_0F0F, 1));
    tag_q.push_back("R10 result despite writes in flight");
    csr_wr(1'b1, data_word(0, 32, 3'b001, 32'hA5A5_0F0F));
    repeat (20) @(negedge clk);
    csr_wr(1'b0, ctrl_word(0, 1, 4'h1));
    csr_wr(1'b1, data_word(1, 4, 3'b001, 32'hFFFF_FFFF));
    wait_idle(d);
    act_q.push_back(d[31:0]);
    csr_rd(1'b0, d); check("R10 control unchanged", d, ctrl_word(2, 0, 4'hF));

    // R11 two command bits
    r0 = rises;
    csr_wr(1'b1, data_word(0, 4, 3'b011, 32'h0000_1234));
    csr_rd(1'b1, d);
    check("R11 no command bit set", 64'(d[42:40]), 64'd0);
    check("R11 window stored", 64'(d[31:0]), 64'h1234);
    repeat (40) @(negedge clk);
    check("R11 no serial activity", 64'(rises - r0), 64'd0);
    check("R11 chain untouched", {63'b0, chain_m[0] === ref_chain[0]}, 64'd1);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule